// File: doc/BRIEF.md
# Soft-Ramp Digital Volume Attenuator

This block scales a stream of 24-bit two's-complement audio samples by a programmable volume. One sample comes in per frame, marked by a valid strobe, and the scaled sample leaves two clocks later. An 8-bit attenuation code selects the target volume. The top code is unity gain. Each lower code adds half a decibel of attenuation down to -63 dB, and the codes below that select silence.

The applied volume never jumps to a new value. It is an internal level index that walks one half-decibel step toward its target, and it takes that step only after a number of frames chosen by a 2-bit speed input. A soft-mute input moves the target to silence, so the volume ramps down. When the input is released the volume ramps back to the programmed code, and it turns around at once if the ramp had not yet finished. A separate hold input forces unity gain while it is high. After it is released the volume ramps from unity toward the programmed code.

The gain for each level comes from a 128-entry table of linear coefficients held in a registered ROM. The multiply rounds its result, and silence produces an exact zero.

Top module: `soft_ramp_attenuator`

## Requirements
- R1: After the synchronous reset, out_valid and out_sample are 0, and the level index is 0, so the first frame passes through at unity gain.
- R2: A code c with c > 0x80 sets the target level index to 0xFF - c (0xFF is 0 dB and 0x81 is -63 dB). Any code of 0x80 or below sets the target to index 128, which is mute, and a frame processed at index 128 outputs exactly 0.
- R3: For an index k below 128 the coefficient is coef[k]. coef[0] = 65536, and coef[k] = floor((coef[k-1]*61870 + 32768) / 65536). The output is floor((sample*coef[k] + 32768) / 65536).
- R4: Each frame strobed on in_valid produces exactly one out_valid pulse two clocks later, carrying that frame's result. Between results, out_sample holds its last value.
- R5: A frame scales its sample with the level index held before that frame. On each frame where the level index differs from the target, an interval counter advances. When the counter would reach N, the index moves one step toward the target and the counter restarts from 0. N is 14, 7, 2 or 2 for speed codes 0, 1, 2 or 3. At the target, the counter is cleared.
- R6: Clocks without in_valid neither move the level index nor advance the interval counter.
- R7: While soft_mute is high the target is index 128. A full ramp from 0xFF therefore first outputs zero at frame 128*N+1. After soft_mute is released, the ramp back to unity takes the same number of frames.
- R8: If soft_mute is released before mute is reached, the index turns back toward the programmed code from the very next frame.
- R9: While hold_unity is high, the level index and interval counter are forced to 0 in the following clock. After release, the level ramps to the programmed code under R5.
- R10: A code change made while muted does not alter the zero output. The new code is kept and becomes the ramp target when soft_mute is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_unity | input | 1 | Internal reset: forces 0 dB while high |
| in_valid | input | 1 | Frame strobe for in_sample |
| in_sample | input | 24 | Input sample, two's complement |
| atten_code | input | 8 | Target attenuation code |
| ramp_speed | input | 2 | Step interval select |
| soft_mute | input | 1 | Ramp toward mute while high |
| out_valid | output | 1 | Result strobe |
| out_sample | output | 24 | Scaled sample |

## Verification
Full-scale positive and negative samples, -1 and +1 at unity gain show whether the rounding and sign handling are exact at the ends of the range. A constant half-scale sample fed through ramps measures the step interval for every speed code and the full mute time. Because the first changed or zero output is counted in frames, an off-by-one in the counter is caught. Frames separated by idle clocks are told apart from back-to-back bursts, which exposes a step counter that advances on clocks instead of frames. A soft mute released mid-ramp, a code changed while muted, and a hold pulse mid-ramp separate target selection from level stepping.

// File: rtl/atten_pkg.sv
package atten_pkg;

  // direction the level index moves in; larger index means more attenuation
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_DEEPER = 2'd1,
    STEP_LOUDER = 2'd2
  } step_dir_e;

  // frames per step for each speed code
  function automatic int unsigned pick_interval(
    input logic [1:0] spd,
    input int unsigned n0,
    input int unsigned n1,
    input int unsigned n2,
    input int unsigned n3
  );
    case (spd)
      2'd0: return n0;
      2'd1: return n1;
      2'd2: return n2;
      default: return n3;
    endcase
  endfunction

endpackage

// File: rtl/atten_gain_rom.sv
module atten_gain_rom #(
  parameter int DEPTH  = 128,
  parameter int COEF_W = 17,
  parameter int FRAC   = 16,
  parameter int RATIO  = 61870,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [COEF_W-1:0] coef
);

  logic [COEF_W-1:0] rom [DEPTH];

  // coefficients are generated by repeated multiplication with a 0.5 dB ratio
  initial begin
    longint acc;
    acc = longint'(1) << FRAC;
    rom[0] = COEF_W'(acc);
    for (int k = 1; k < DEPTH; k++) begin
      acc = (acc * longint'(RATIO) + (longint'(1) << (FRAC - 1))) >> FRAC;
      rom[k] = COEF_W'(acc);
    end
  end

  always_ff @(posedge clk) begin
    coef <= rom[addr];
  end

endmodule

// File: rtl/atten_level_ramp.sv
module atten_level_ramp
  import atten_pkg::*;
#(
  parameter int STEPS  = 128,
  parameter int CODE_W = 8,
  parameter int INTV0  = 14,
  parameter int INTV1  = 7,
  parameter int INTV2  = 2,
  parameter int INTV3  = 2,
  localparam int LVL_W = $clog2(STEPS + 1),
  localparam int MAX_I = (INTV0 > INTV1 ? INTV0 : INTV1) > (INTV2 > INTV3 ? INTV2 : INTV3)
                       ? (INTV0 > INTV1 ? INTV0 : INTV1) : (INTV2 > INTV3 ? INTV2 : INTV3),
  localparam int CNT_W = $clog2(MAX_I + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_i,
  input  logic              frame_i,
  input  logic              smute_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        speed_i,
  output logic [LVL_W-1:0]  level_o
);

  localparam int FULL = (1 << CODE_W) - 1;
  localparam int MUTE_EDGE = FULL - (STEPS - 1);

  logic [LVL_W-1:0] level_q;
  logic [LVL_W-1:0] code_lvl;
  logic [LVL_W-1:0] target;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_next;
  logic [CNT_W:0]   interval;
  step_dir_e        dir;

  // code to level index: audible codes count down from full scale, rest is mute
  always_comb begin
    if (int'(code_i) > MUTE_EDGE) code_lvl = LVL_W'(FULL - int'(code_i));
    else                          code_lvl = LVL_W'(STEPS);
  end

  assign target   = smute_i ? LVL_W'(STEPS) : code_lvl;
  assign interval = (CNT_W + 1)'(pick_interval(speed_i, INTV0, INTV1, INTV2, INTV3));
  assign cnt_next = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    if (level_q < target)      dir = STEP_DEEPER;
    else if (level_q > target) dir = STEP_LOUDER;
    else                       dir = STEP_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      level_q <= '0;
      cnt_q   <= '0;
    end else if (frame_i) begin
      if (dir == STEP_NONE) begin
        cnt_q <= '0;
      end else if (cnt_next >= interval) begin
        cnt_q <= '0;
        if (dir == STEP_DEEPER) level_q <= level_q + 1'b1;
        else                    level_q <= level_q - 1'b1;
      end else begin
        cnt_q <= cnt_next[CNT_W-1:0];
      end
    end
  end

  assign level_o = level_q;

  // R5: the level never moves more than one step per clock
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    !hold_i |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1)
                || (level_q + 1'b1 == $past(level_q)));

  // R6: no frame, no movement
  a_r6_still_between_frames: assert property (@(posedge clk) disable iff (rst)
    (!frame_i && !hold_i) |=> $stable(level_q));

  // R5: a level already at its target stays there
  a_r5_still_at_target: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && level_q == target) |=> $stable(level_q));

  // R9: hold forces unity gain
  a_r9_hold_unity: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> level_q == '0);

  // R2: index never passes the mute level
  a_r2_level_bounded: assert property (@(posedge clk) disable iff (rst)
    level_q <= LVL_W'(STEPS));

endmodule

// File: rtl/atten_scaler.sv
module atten_scaler #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 17,
  parameter int FRAC   = 16,
  localparam int PW    = DATA_W + COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     in_mute,
  input  logic [COEF_W-1:0]        coef_i,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);

  localparam logic signed [PW-1:0] HALF  = PW'(1) <<< (FRAC - 1);
  localparam logic [COEF_W-1:0]    UNITY = COEF_W'(1) << FRAC;

  // stage 1 is aligned with the registered coefficient read
  logic                     v1;
  logic                     m1;
  logic signed [DATA_W-1:0] s1;
  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     rounded;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      m1 <= 1'b0;
      s1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        s1 <= in_sample;
        m1 <= in_mute;
      end
    end
  end

  assign prod    = PW'(s1) * $signed({1'b0, coef_i});
  assign rounded = (prod + HALF) >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_sample <= m1 ? '0 : rounded[DATA_W-1:0];
    end
  end

  // R2: a muted frame leaves as zero
  a_r2_mute_zero: assert property (@(posedge clk) disable iff (rst)
    (v1 && m1) |=> out_sample == '0);

  // R4: result strobe follows the first stage by one clock
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    v1 |=> out_valid);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> !out_valid && $stable(out_sample));

  // R3: unity coefficient passes the sample unchanged
  a_r3_unity_pass: assert property (@(posedge clk) disable iff (rst)
    (v1 && !m1 && coef_i == UNITY) |=> out_sample == $past(s1));

endmodule

// File: rtl/soft_ramp_attenuator.sv
module soft_ramp_attenuator #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8,
  parameter int STEPS  = 128,
  parameter int COEF_W = 17,
  parameter int FRAC   = 16,
  parameter int RATIO  = 61870,
  parameter int INTV0  = 14,
  parameter int INTV1  = 7,
  parameter int INTV2  = 2,
  parameter int INTV3  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_unity,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [CODE_W-1:0] atten_code,
  input  logic [1:0]        ramp_speed,
  input  logic              soft_mute,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);

  localparam int LVL_W = $clog2(STEPS + 1);
  localparam int AW    = $clog2(STEPS);

  logic [LVL_W-1:0]         level;
  logic [COEF_W-1:0]        coef;
  logic                     mute_now;
  logic signed [DATA_W-1:0] res;

  atten_level_ramp #(
    .STEPS(STEPS), .CODE_W(CODE_W),
    .INTV0(INTV0), .INTV1(INTV1), .INTV2(INTV2), .INTV3(INTV3)
  ) u_ramp (
    .clk(clk), .rst(rst), .hold_i(hold_unity), .frame_i(in_valid),
    .smute_i(soft_mute), .code_i(atten_code), .speed_i(ramp_speed),
    .level_o(level)
  );

  atten_gain_rom #(
    .DEPTH(STEPS), .COEF_W(COEF_W), .FRAC(FRAC), .RATIO(RATIO)
  ) u_rom (
    .clk(clk), .addr(level[AW-1:0]), .coef(coef)
  );

  assign mute_now = (level == LVL_W'(STEPS));

  atten_scaler #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)
  ) u_scale (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample($signed(in_sample)),
    .in_mute(mute_now), .coef_i(coef), .out_valid(out_valid), .out_sample(res)
  );

  assign out_sample = res;

endmodule

// File: tb/test_soft_ramp_attenuator.sv
module test_soft_ramp_attenuator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst = 1'b1;
  logic        hold_unity = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_sample = '0;
  logic [7:0]  atten_code = 8'hFF;
  logic [1:0]  ramp_speed = 2'd0;
  logic        soft_mute = 1'b0;
  logic        out_valid;
  logic [23:0] out_sample;

  soft_ramp_attenuator i_soft_ramp_attenuator (
    .clk(clk), .rst(rst), .hold_unity(hold_unity), .in_valid(in_valid),
    .in_sample(in_sample), .atten_code(atten_code), .ramp_speed(ramp_speed),
    .soft_mute(soft_mute), .out_valid(out_valid), .out_sample(out_sample)
  );

  int checks = 0;
  int failures = 0;
  string phase = "R1";
  longint coef_tab [128];
  int m_lvl = 0, m_cnt = 0;
  bit p_v = 0, e_v = 0;
  longint p_d = 0, e_d = 0;
  int intervals [4] = '{14, 7, 2, 2};

  function automatic longint gain(longint s, int lvl);
    if (lvl >= 128) return 0;
    return (s * coef_tab[lvl] + 32768) >>> 16;
  endfunction

  function automatic int target_of(logic [7:0] c, bit mute);
    if (mute) return 128;
    if (c > 8'h80) return 255 - int'(c);
    return 128;
  endfunction

  task automatic chk(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance one clock, updating the reference model and comparing outputs
  task automatic cycle();
    if (rst) begin
      m_lvl = 0; m_cnt = 0; p_v = 0; p_d = 0; e_v = 0; e_d = 0;
    end else begin
      e_v = p_v;
      if (p_v) e_d = p_d;
      p_v = in_valid;
      if (in_valid) p_d = gain(longint'($signed(in_sample)), m_lvl);
      if (hold_unity) begin
        m_lvl = 0; m_cnt = 0;
      end else if (in_valid) begin
        int tgt = target_of(atten_code, soft_mute);
        if (m_lvl == tgt) m_cnt = 0;
        else if (m_cnt + 1 >= intervals[ramp_speed]) begin
          m_cnt = 0;
          m_lvl += (m_lvl < tgt) ? 1 : -1;
        end else m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(phase, longint'(out_valid), longint'(e_v), "out_valid");
    chk(phase, longint'($signed(out_sample)), e_d, "out_sample");
  endtask

  task automatic send_frame(input longint s, output longint r);
    in_valid = 1'b1; in_sample = 24'(s);
    cycle();
    in_valid = 1'b0;
    cycle();
    cycle();
    r = longint'($signed(out_sample));
  endtask

  task automatic pulse_hold();
    hold_unity = 1'b1; cycle(); hold_unity = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    longint r;
    int k;
    coef_tab[0] = 65536;
    for (int i = 1; i < 128; i++) coef_tab[i] = (coef_tab[i-1] * 61870 + 32768) / 65536;

    // R1 reset state
    @(negedge clk);
    cycle(); cycle();
    rst = 1'b0;
    chk("R1", longint'(out_valid), 0, "out_valid after reset");
    chk("R1", longint'(out_sample), 0, "out_sample after reset");
    send_frame(123456, r);
    chk("R1", r, 123456, "unity after reset");

    // R4 latency of a single frame
    phase = "R4";
    in_valid = 1'b1; in_sample = 24'd777; cycle();
    in_valid = 1'b0;
    chk("R4", longint'(out_valid), 0, "valid one clock after frame");
    cycle();
    chk("R4", longint'(out_valid), 1, "valid two clocks after frame");
    cycle();
    chk("R4", longint'(out_valid), 0, "single pulse");
    chk("R4", longint'($signed(out_sample)), 777, "held result");

    // R3 extremes at unity
    phase = "R3";
    send_frame(8388607, r);  chk("R3", r, 8388607, "max positive");
    send_frame(-8388608, r); chk("R3", r, -8388608, "max negative");
    send_frame(-1, r);       chk("R3", r, -1, "minus one");
    send_frame(1, r);        chk("R3", r, 1, "plus one");

    // R2 R3 settle at code 0xF5 (index 10)
    phase = "R2";
    atten_code = 8'hF5; ramp_speed = 2'd3;
    for (int i = 0; i < 30; i++) send_frame(4194304, r);
    send_frame(4194304, r);  chk("R2", r, gain(4194304, 10), "code F5 level");
    send_frame(-3000001, r); chk("R3", r, gain(-3000001, 10), "negative rounding");
    send_frame(12345, r);    chk("R3", r, gain(12345, 10), "small rounding");

    // R5 R9 step interval for every speed
    phase = "R5";
    for (int sp = 0; sp < 4; sp++) begin
      atten_code = 8'hFE; ramp_speed = 2'(sp);
      pulse_hold();
      k = 0;
      do begin k++; send_frame(4194304, r); end while (r == 4194304 && k < 40);
      chk("R5", k, intervals[sp] + 1, "first stepped frame");
    end

    // R6 back-to-back burst and sparse frames
    phase = "R6";
    atten_code = 8'hE0; ramp_speed = 2'd1;
    pulse_hold();
    for (int i = 0; i < 40; i++) begin
      in_valid = 1'b1; in_sample = 24'(i * 9001 - 150000); cycle();
    end
    in_valid = 1'b0;
    for (int i = 0; i < 60; i++) begin
      in_valid = (i % 3 == 0); in_sample = 24'(-i * 777); cycle();
    end
    in_valid = 1'b0; cycle(); cycle();
    ramp_speed = 2'd2; atten_code = 8'hFE; pulse_hold();
    send_frame(4194304, r);
    repeat (10) cycle();
    send_frame(4194304, r); chk("R6", r, 4194304, "idle clocks do not step");
    send_frame(4194304, r); chk("R6", r, gain(4194304, 1), "third frame steps");

    // R7 full ramp to mute and back at speed 2
    phase = "R7";
    atten_code = 8'hFF; pulse_hold();
    soft_mute = 1'b1;
    k = 0;
    do begin k++; send_frame(4194304, r); end while (r != 0 && k < 400);
    chk("R7", k, 257, "first muted frame");
    soft_mute = 1'b0;
    for (int i = 1; i <= 255; i++) send_frame(4194304, r);
    send_frame(4194304, r); chk("R7", r, gain(4194304, 1), "frame 256 of release");
    send_frame(4194304, r); chk("R7", r, 4194304, "frame 257 back at unity");

    // R8 reversal mid-ramp at speed 1
    phase = "R8";
    ramp_speed = 2'd1; pulse_hold();
    soft_mute = 1'b1;
    for (int i = 0; i < 35; i++) send_frame(4194304, r);
    chk("R8", r, gain(4194304, 4), "level before release");
    soft_mute = 1'b0;
    for (int i = 0; i < 34; i++) send_frame(4194304, r);
    send_frame(4194304, r); chk("R8", r, gain(4194304, 1), "frame 70");
    send_frame(4194304, r); chk("R8", r, 4194304, "frame 71 unity");

    // R2 mute codes and the deepest audible code
    phase = "R2";
    ramp_speed = 2'd3;
    atten_code = 8'h81;
    for (int i = 0; i < 260; i++) send_frame(4194304, r);
    chk("R2", r, gain(4194304, 126), "code 81 is -63 dB");
    atten_code = 8'h80; for (int i = 0; i < 6; i++) send_frame(4194304, r);
    chk("R2", r, 0, "code 80 mutes");
    atten_code = 8'h00; send_frame(-4194304, r);
    chk("R2", r, 0, "code 00 mutes");

    // R10 code change while muted is kept
    phase = "R10";
    atten_code = 8'hF0; soft_mute = 1'b1;
    for (int i = 0; i < 4; i++) send_frame(4194304, r);
    chk("R10", r, 0, "stays muted after code change");
    soft_mute = 1'b0;
    for (int i = 0; i < 300; i++) send_frame(4194304, r);
    chk("R10", r, gain(4194304, 15), "settles at new code");

    // R9 hold mid-ramp
    phase = "R9";
    ramp_speed = 2'd0; atten_code = 8'h90;
    for (int i = 0; i < 100; i++) send_frame(4194304, r);
    pulse_hold();
    send_frame(4194304, r); chk("R9", r, 4194304, "unity after hold");

    finish_run();
  end
endmodule